// File: doc/BRIEF.md
# Request-Acknowledge Window Checker

This block is a synthesizable protocol monitor. It watches a one-bit request line and a one-bit acknowledge line in one clock domain. Every request must be answered by exactly one acknowledge between one and `MAX_WAIT` cycles after it is sampled. Every acknowledge must use up exactly one earlier request that is still unanswered and still inside that window.

More than one request may be outstanding at a time. Pending requests are kept in issue order, each with an age counter. An acknowledge always retires the oldest pending request. A request that reaches the end of its window without an answer is dropped and flagged. An acknowledge that finds nothing to retire is flagged as an orphan.

The block is meant to sit beside a handshake in silicon or in emulation. Its error pulses can feed an interrupt or a sticky flag elsewhere.

Top module: `rak_window_checker`

## Requirements
- R1: While `rst_ni` is low, `timeout_o` and `orphan_o` are 0 and `outstanding_o` is 0, whatever the inputs do.
- R2: A request sampled at one clock edge is retired without error by an acknowledge sampled 1 to `MAX_WAIT` (default 5) edges later. `outstanding_o` drops by one after that acknowledge.
- R3: Suppose a pending request reaches age `MAX_WAIT` at an edge where no acknowledge is sampled. `timeout_o` is then high for the following cycle, and the request is removed.
- R4: An acknowledge sampled while no request is pending raises `orphan_o` for the following cycle. The pending set is unchanged by that acknowledge.
- R5: An acknowledge never retires a request sampled at the same edge. With nothing older pending, this is an orphan, and the new request is still counted.
- R6: Pending requests are retired oldest first, and each one only once. Two requests followed by three acknowledges give two matches and one orphan.
- R7: `outstanding_o` equals the number of pending requests. It rises by one on a request-only edge, falls by one on a matching acknowledge or a timeout, and holds when a request and a matching acknowledge share an edge.
- R8: An acknowledge exactly `MAX_WAIT` edges after its request matches. An acknowledge one edge later finds the request already timed out and is an orphan. `timeout_o` and `orphan_o` are never high together.
- R9: A request on every edge never overflows the pending store. Each of those requests times out on its own edge, one per cycle in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request line being monitored |
| ack_i | input | 1 | Acknowledge line being monitored |
| timeout_o | output | 1 | One-cycle pulse: a request went unanswered past the window |
| orphan_o | output | 1 | One-cycle pulse: an acknowledge had no pending request |
| outstanding_o | output | $clog2(MAX_WAIT+2) | Number of pending requests |

## Verification
A new request and an acknowledge of an older request can land on the same clock edge. The acknowledge must then retire the older entry while the new one enters the store, and the count must hold. The bench provokes this with directed req-plus-ack edges, both with an older entry pending and with none pending. It also raises both lines together often in a long seeded random run. Every edge is judged against a bench-side ordered model of ages, which predicts the error pulses and the count.

// File: rtl/rak_pkg.sv
package rak_pkg;
  typedef struct packed {
    logic match;
    logic timeout;
    logic orphan;
  } verdict_t;
endpackage

// File: rtl/rak_age_queue.sv
module rak_age_queue #(
  parameter int MAX_WAIT = 5,
  parameter int DEPTH    = MAX_WAIT + 1,
  parameter int AGE_W    = $clog2(MAX_WAIT + 2),
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             head_vld_o,
  output logic [AGE_W-1:0] head_age_o,
  output logic [CNT_W-1:0] occ_o
);
  logic [DEPTH-1:0] vld_q, sh_vld, push_here, nxt_vld;
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [AGE_W-1:0] sh_age [DEPTH];
  logic [AGE_W-1:0] nxt_age [DEPTH];

  // compacted store: head at index 0, pop shifts down
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      assign sh_vld[i] = pop_i ? vld_q[i+1] : vld_q[i];
      assign sh_age[i] = pop_i ? age_q[i+1] : age_q[i];
    end else begin : g_last
      assign sh_vld[i] = pop_i ? 1'b0 : vld_q[i];
      assign sh_age[i] = pop_i ? '0 : age_q[i];
    end
    if (i == 0) begin : g_first
      assign push_here[i] = push_i && !sh_vld[i];
    end else begin : g_rest
      assign push_here[i] = push_i && !sh_vld[i] && sh_vld[i-1];
    end
    assign nxt_vld[i] = sh_vld[i] | push_here[i];
    assign nxt_age[i] = push_here[i] ? AGE_W'(1)
                      : (sh_vld[i] ? sh_age[i] + AGE_W'(1) : '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        age_q[i] <= '0;
      end else begin
        vld_q[i] <= nxt_vld[i];
        age_q[i] <= nxt_age[i];
      end
    end

    if (i < DEPTH - 1) begin : g_ord
      a_r6_age_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q[i+1] |-> (vld_q[i] && (age_q[i] > age_q[i+1])));
    end
  end

  assign head_vld_o = vld_q[0];
  assign head_age_o = age_q[0];
  assign occ_o      = CNT_W'($countones(vld_q));

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> !vld_q[DEPTH-1]);

  a_r3_head_age_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q[0] |-> (age_q[0] >= AGE_W'(1) && age_q[0] <= AGE_W'(MAX_WAIT)));
endmodule

// File: rtl/rak_verdict.sv
module rak_verdict
  import rak_pkg::*;
#(
  parameter int MAX_WAIT = 5,
  parameter int AGE_W    = $clog2(MAX_WAIT + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             head_vld_i,
  input  logic [AGE_W-1:0] head_age_i,
  output logic             pop_o,
  output logic             timeout_o,
  output logic             orphan_o
);
  verdict_t v;

  always_comb begin
    v.match   = ack_i && head_vld_i;
    v.orphan  = ack_i && !head_vld_i;
    // an ack on the last legal edge wins over expiry
    v.timeout = !ack_i && head_vld_i && (head_age_i == AGE_W'(MAX_WAIT));
  end

  assign pop_o = v.match || v.timeout;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_o <= 1'b0;
      orphan_o  <= 1'b0;
    end else begin
      timeout_o <= v.timeout;
      orphan_o  <= v.orphan;
    end
  end

  a_r8_errs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(timeout_o && orphan_o));
  a_r4_orphan_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orphan_o |-> $past(ack_i));
  a_r3_timeout_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !$past(ack_i));
endmodule

// File: rtl/rak_occ_counter.sv
module rak_occ_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (inc_i && !dec_i) cnt_o <= cnt_o + CNT_W'(1);
    else if (dec_i && !inc_i) cnt_o <= cnt_o - CNT_W'(1);
  end

  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i) |-> (cnt_o != '0));
endmodule

// File: rtl/rak_window_checker.sv
module rak_window_checker #(
  parameter int MAX_WAIT = 5,
  localparam int DEPTH   = MAX_WAIT + 1,
  localparam int AGE_W   = $clog2(MAX_WAIT + 2),
  localparam int CNT_W   = $clog2(MAX_WAIT + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ack_i,
  output logic             timeout_o,
  output logic             orphan_o,
  output logic [CNT_W-1:0] outstanding_o
);
  logic             head_vld, pop;
  logic [AGE_W-1:0] head_age;
  logic [CNT_W-1:0] occ;

  rak_age_queue #(
    .MAX_WAIT(MAX_WAIT), .DEPTH(DEPTH), .AGE_W(AGE_W), .CNT_W(CNT_W)
  ) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(req_i), .pop_i(pop),
    .head_vld_o(head_vld), .head_age_o(head_age), .occ_o(occ)
  );

  rak_verdict #(.MAX_WAIT(MAX_WAIT), .AGE_W(AGE_W)) u_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i),
    .head_vld_i(head_vld), .head_age_i(head_age),
    .pop_o(pop), .timeout_o(timeout_o), .orphan_o(orphan_o)
  );

  rak_occ_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(req_i), .dec_i(pop),
    .cnt_o(outstanding_o)
  );

  a_r7_cnt_tracks_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding_o == occ);
  a_r4_orphan_keeps_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !head_vld) |=> (outstanding_o == $past(outstanding_o) + CNT_W'($past(req_i))));
  a_r5_same_edge_orphan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ack_i && !head_vld) |=> orphan_o);
endmodule

// File: tb/sim_rak_window_checker.sv
module sim_rak_window_checker;
  localparam int MAX_WAIT = 5;
  localparam int CNT_W    = $clog2(MAX_WAIT + 2);

  logic clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0, ack_i = 1'b0;
  logic timeout_o, orphan_o;
  logic [CNT_W-1:0] outstanding_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  rak_window_checker #(.MAX_WAIT(MAX_WAIT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ack_i(ack_i),
    .timeout_o(timeout_o), .orphan_o(orphan_o), .outstanding_o(outstanding_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mq[8];
  int mn;
  bit e_to, e_or;
  int e_cnt;

  function void model_reset();
    mn = 0; e_to = 0; e_or = 0; e_cnt = 0;
  endfunction

  function void model_pop();
    for (int i = 0; i < mn - 1; i++) mq[i] = mq[i+1];
    mn--;
  endfunction

  function void model_step(bit r, bit a);
    e_to = 0; e_or = 0;
    if (a) begin
      if (mn > 0) model_pop(); else e_or = 1;
    end else if (mn > 0 && mq[0] == MAX_WAIT) begin
      model_pop(); e_to = 1;
    end
    for (int i = 0; i < mn; i++) mq[i]++;
    if (r) begin mq[mn] = 1; mn++; end
    e_cnt = mn;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit a, string tag);
    @(negedge clk_i);
    req_i = r; ack_i = a;
    model_step(r, a);
    @(posedge clk_i);
    #1;
    check(tag, "timeout", int'(timeout_o), int'(e_to));
    check(tag, "orphan", int'(orphan_o), int'(e_or));
    check(tag, "count", int'(outstanding_o), e_cnt);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    // R1: reset holds everything low despite activity
    req_i = 1'b1; ack_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", "timeout", int'(timeout_o), 0);
    check("R1", "orphan", int'(orphan_o), 0);
    check("R1", "count", int'(outstanding_o), 0);
    req_i = 1'b0; ack_i = 1'b0;
    rst_ni = 1'b1;

    // R2: ack three edges after request
    step(1, 0, "R2"); idle(2, "R2"); step(0, 1, "R2"); idle(2, "R2");
    // R4: lone ack
    step(0, 1, "R4"); idle(1, "R4");
    // R5: req and ack together with nothing pending
    step(1, 1, "R5"); idle(7, "R5");
    // R6: two reqs, three acks
    step(1, 0, "R6"); step(1, 0, "R6");
    step(0, 1, "R6"); step(0, 1, "R6"); step(0, 1, "R6"); idle(2, "R6");
    // R7: req then req+matching ack holds count
    step(1, 0, "R7"); step(1, 1, "R7"); idle(7, "R7");
    // R8: ack exactly at window end, then one edge late
    step(1, 0, "R8"); idle(4, "R8"); step(0, 1, "R8");
    step(1, 0, "R8"); idle(4, "R8"); step(0, 0, "R8"); step(0, 1, "R8"); idle(2, "R8");
    // R3: plain timeout
    step(1, 0, "R3"); idle(7, "R3");
    // R9: request every edge, then drain by timeouts
    for (int i = 0; i < 12; i++) step(1, 0, "R9");
    idle(8, "R9");

    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      bit r, a;
      r = ($urandom % 3) == 0;
      a = ($urandom % 4) == 0;
      step(r, a, "R7");
    end
    idle(8, "R3");

    done = 1;
    summary();
    $finish;
  end
endmodule